// File: doc/BRIEF.md
# Vector Any-Element-Zero Branch Unit

This block resolves a conditional branch that tests a 128-bit vector register for a zero element. Each cycle that `valid_i` is high it takes one 32-bit instruction word, the value already read for the named vector register, the branch PC, and two context flags. The first flag says whether the vector unit is enabled. The second says whether this instruction sits in the delay slot of an earlier branch. One cycle later it presents the decode result, the taken decision, the branch target and any exception requests, and marks them with `valid_o`.

The instruction's format field picks the element size: byte, halfword, word or doubleword. The operand is cut into lanes of that size, and the branch is taken when any lane equals zero. The target is relative to the delay-slot PC, so the branch PC plus 4, and the offset counts instructions. The PC update itself happens after the delay slot. That is the pipeline's job, and this block only supplies the target.

Top module: `vzb_branch_unit`

## Requirements
- R1: A hit (`hit_o`=1) is reported when instruction bits [31:26] equal 6'b010001. `vreg_o` then carries bits [20:16]. For any other major opcode, `hit_o`, `taken_o` and both exception outputs stay 0.
- R2: On a hit whose sub-opcode (bits [25:23]) is not 3'b110, `ri_exc_o`=1, `vdis_exc_o`=0 and `taken_o`=0.
- R3: On a hit with sub-opcode 3'b110 and `vec_en_i`=1, `taken_o`=1 exactly when at least one lane of `vec_i` is zero. The lane size comes from bits [22:21]: 00 selects 16 byte lanes, 01 selects 8 halfword lanes, 10 selects 4 word lanes and 11 selects 2 doubleword lanes. Lane k occupies bits [k*size +: size].
- R4: On a hit, `target_o` = `pc_i` + 4 + (sign-extended bits [15:0] shifted left by 2), modulo 2^32.
- R5: On a hit with sub-opcode 3'b110 and `vec_en_i`=0, `vdis_exc_o`=1, `ri_exc_o`=0 and `taken_o`=0, whatever the operand holds.
- R6: `dslot_hazard_o`=1 exactly when a hit arrives with `in_dslot_i`=1.
- R7: Every output is registered. `valid_o` follows `valid_i` by one clock. When `valid_o`=0, all flag outputs are 0.
- R8: While `rst_ni` is low, `valid_o` and all flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| instr_i | input | 32 | Instruction word |
| vec_i | input | 128 | Vector register operand |
| pc_i | input | 32 | PC of the branch |
| vec_en_i | input | 1 | Vector unit enabled |
| in_dslot_i | input | 1 | Instruction sits in a delay slot |
| valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Major opcode matched |
| vreg_o | output | 5 | Vector register index |
| taken_o | output | 1 | Branch taken |
| target_o | output | 32 | Branch target PC |
| ri_exc_o | output | 1 | Reserved-instruction exception request |
| vdis_exc_o | output | 1 | Vector-unit-disabled exception request |
| dslot_hazard_o | output | 1 | Branch found in a delay slot |

## Verification
The assertions assume that `vec_i`, `pc_i` and the context flags are stable and meaningful in every cycle where `valid_i` is high. They also assume that an all-zero operand with a well-formed, enabled instruction must branch, whatever the format. The bench drives every input at the falling edge and holds it over the capturing edge. It mixes random words with a forced major opcode, and it plants zero lanes of a random size in otherwise nonzero operands, so that both the taken and the not-taken cases occur in every format. Directed cases cover offsets at the signed extremes, PC wraparound, and a single zero byte that lies inside a nonzero wider lane.

// File: rtl/vzb_pkg.sv
package vzb_pkg;
  localparam int unsigned INSTR_W  = 32;
  localparam int unsigned OFF_W    = 16;
  localparam int unsigned REG_W    = 5;
  localparam logic [5:0]  MAJOR_OP = 6'b010001;
  localparam logic [2:0]  SUB_OP   = 3'b110;

  typedef enum logic [1:0] {
    FMT_B = 2'b00,
    FMT_H = 2'b01,
    FMT_W = 2'b10,
    FMT_D = 2'b11
  } lane_fmt_e;

  typedef struct packed {
    logic             major_ok;
    logic             sub_ok;
    lane_fmt_e        fmt;
    logic [REG_W-1:0] vreg;
    logic [OFF_W-1:0] off;
  } dec_t;
endpackage

// File: rtl/vzb_decode.sv
module vzb_decode
  import vzb_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  always_comb begin
    dec_o.major_ok = (instr_i[31:26] == MAJOR_OP);
    dec_o.sub_ok   = (instr_i[25:23] == SUB_OP);
    dec_o.fmt      = lane_fmt_e'(instr_i[22:21]);
    dec_o.vreg     = instr_i[20:16];
    dec_o.off      = instr_i[15:0];
  end
endmodule

// File: rtl/vzb_zero_tree.sv
module vzb_zero_tree
  import vzb_pkg::*;
#(
  parameter int unsigned VLEN      = 128,
  parameter int unsigned MIN_LANE  = 8,
  parameter int unsigned NUM_SIZES = 4
) (
  input  logic [VLEN-1:0] vec_i,
  input  lane_fmt_e       fmt_i,
  output logic            any_zero_o
);
  localparam int unsigned NB = VLEN / MIN_LANE;

  logic [NUM_SIZES-1:0][NB-1:0] zt;
  logic [NUM_SIZES-1:0]         lvl_any;

  // level 0: smallest lanes; each higher level pairs neighbours
  for (genvar i = 0; i < NB; i++) begin : g_l0
    assign zt[0][i] = ~|vec_i[i*MIN_LANE +: MIN_LANE];
  end

  for (genvar l = 1; l < NUM_SIZES; l++) begin : g_lvl
    for (genvar i = 0; i < NB; i++) begin : g_bit
      if (i < (NB >> l)) begin : g_pair
        assign zt[l][i] = zt[l-1][2*i] & zt[l-1][2*i+1];
      end else begin : g_pad
        assign zt[l][i] = 1'b0;
      end
    end
  end

  for (genvar l = 0; l < NUM_SIZES; l++) begin : g_any
    assign lvl_any[l] = |zt[l];
  end

  always_comb begin
    unique case (fmt_i)
      FMT_B:   any_zero_o = lvl_any[0];
      FMT_H:   any_zero_o = lvl_any[1];
      FMT_W:   any_zero_o = lvl_any[2];
      default: any_zero_o = lvl_any[3];
    endcase
  end
endmodule

// File: rtl/vzb_target.sv
module vzb_target
  import vzb_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned SLOT_B = 4
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W - 2;

  logic [PC_W-1:0] slot_pc;
  logic [PC_W-1:0] disp;

  assign slot_pc  = pc_i + PC_W'(SLOT_B);
  assign disp     = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign target_o = slot_pc + disp;
endmodule

// File: rtl/vzb_branch_unit.sv
module vzb_branch_unit
  import vzb_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned PC_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [VLEN-1:0]    vec_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic               vec_en_i,
  input  logic               in_dslot_i,
  output logic               valid_o,
  output logic               hit_o,
  output logic [REG_W-1:0]   vreg_o,
  output logic               taken_o,
  output logic [PC_W-1:0]    target_o,
  output logic               ri_exc_o,
  output logic               vdis_exc_o,
  output logic               dslot_hazard_o
);
  dec_t            dec;
  logic            any_zero;
  logic [PC_W-1:0] tgt;

  vzb_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  vzb_zero_tree #(
    .VLEN      (VLEN),
    .MIN_LANE  (8),
    .NUM_SIZES (4)
  ) u_zt (
    .vec_i      (vec_i),
    .fmt_i      (dec.fmt),
    .any_zero_o (any_zero)
  );

  vzb_target #(
    .PC_W   (PC_W),
    .SLOT_B (4)
  ) u_tgt (
    .pc_i     (pc_i),
    .off_i    (dec.off),
    .target_o (tgt)
  );

  logic hit_n, ri_n, vdis_n, taken_n, haz_n;

  always_comb begin
    hit_n   = valid_i & dec.major_ok;
    ri_n    = hit_n & ~dec.sub_ok;
    vdis_n  = hit_n & dec.sub_ok & ~vec_en_i;
    taken_n = hit_n & dec.sub_ok & vec_en_i & any_zero;
    haz_n   = hit_n & in_dslot_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      hit_o          <= 1'b0;
      taken_o        <= 1'b0;
      ri_exc_o       <= 1'b0;
      vdis_exc_o     <= 1'b0;
      dslot_hazard_o <= 1'b0;
      vreg_o         <= '0;
      target_o       <= '0;
    end else begin
      valid_o        <= valid_i;
      hit_o          <= hit_n;
      taken_o        <= taken_n;
      ri_exc_o       <= ri_n;
      vdis_exc_o     <= vdis_n;
      dslot_hazard_o <= haz_n;
      if (valid_i) begin
        vreg_o   <= dec.vreg;
        target_o <= tgt;
      end
    end
  end
endmodule

// File: rtl/vzb_branch_unit_chk.sv
module vzb_branch_unit_chk #(
  parameter int unsigned VLEN = 128,
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [31:0]     instr_i,
  input logic [VLEN-1:0] vec_i,
  input logic            vec_en_i,
  input logic            in_dslot_i,
  input logic            valid_o,
  input logic            hit_o,
  input logic            taken_o,
  input logic            ri_exc_o,
  input logic            vdis_exc_o,
  input logic            dslot_hazard_o
);
  assert_valid_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !(hit_o | taken_o | ri_exc_o | vdis_exc_o | dslot_hazard_o));
  assert_taken_needs_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> hit_o && !ri_exc_o && !vdis_exc_o);
  assert_exc_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ri_exc_o, vdis_exc_o}));
  assert_disabled_no_take_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !vec_en_i |=> !taken_o);
  assert_all_zero_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && vec_en_i && instr_i[31:23] == 9'b010001_110 && vec_i == '0 |=> taken_o);
  assert_hazard_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && in_dslot_i && instr_i[31:26] == 6'b010001 |=> dslot_hazard_o);
  always_comb begin
    if (!rst_ni) assert_reset_quiet_R8: assert (!valid_o && !taken_o && !hit_o);
  end
endmodule

bind vzb_branch_unit vzb_branch_unit_chk #(.VLEN(VLEN), .PC_W(PC_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .instr_i        (instr_i),
  .vec_i          (vec_i),
  .vec_en_i       (vec_en_i),
  .in_dslot_i     (in_dslot_i),
  .valid_o        (valid_o),
  .hit_o          (hit_o),
  .taken_o        (taken_o),
  .ri_exc_o       (ri_exc_o),
  .vdis_exc_o     (vdis_exc_o),
  .dslot_hazard_o (dslot_hazard_o)
);

// File: tb/tb_vzb_branch_unit.sv
`timescale 1ns/1ps
module tb_vzb_branch_unit;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [31:0]  instr_i = '0;
  logic [127:0] vec_i = '0;
  logic [31:0]  pc_i = '0;
  logic         vec_en_i = 1'b0;
  logic         in_dslot_i = 1'b0;
  logic         valid_o, hit_o, taken_o, ri_exc_o, vdis_exc_o, dslot_hazard_o;
  logic [4:0]   vreg_o;
  logic [31:0]  target_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  vzb_branch_unit dut (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit any_zero(logic [127:0] v, logic [1:0] df);
    int sz = 8 << df;
    logic [127:0] m = (128'd1 << sz) - 128'd1;
    for (int i = 0; i < 128 / sz; i++)
      if (((v >> (i * sz)) & m) == '0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_tgt(logic [31:0] pc, logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  function automatic logic [127:0] nz_vec();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = $urandom();
    for (int i = 0; i < 16; i++) if (v[i*8 +: 8] == 8'h0) v[i*8] = 1'b1;
    return v;
  endfunction

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic run(logic [31:0] ins, logic [127:0] v, logic [31:0] pc, bit en, bit ds);
    bit hit, subok;
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = ins; vec_i = v; pc_i = pc; vec_en_i = en; in_dslot_i = ds;
    @(negedge clk_i);
    valid_i = 1'b0;
    hit   = ins[31:26] == 6'b010001;
    subok = ins[25:23] == 3'b110;
    chk("R7 valid", valid_o, 1);
    chk("R1 hit", hit_o, hit);
    if (hit) begin
      chk("R1 vreg", vreg_o, ins[20:16]);
      chk("R4 target", target_o, exp_tgt(pc, ins[15:0]));
    end
    chk("R2 ri", ri_exc_o, hit && !subok);
    chk("R5 vdis", vdis_exc_o, hit && subok && !en);
    chk("R3 taken", taken_o, hit && subok && en && any_zero(v, ins[22:21]));
    chk("R6 hazard", dslot_hazard_o, hit && ds);
  endtask

  function automatic logic [31:0] mk(logic [1:0] df, logic [4:0] r, logic [15:0] off);
    return {6'b010001, 3'b110, df, r, off};
  endfunction

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk("R8 reset valid", valid_o, 0);
    chk("R8 reset taken", taken_o, 0);
    chk("R8 reset exc", {ri_exc_o, vdis_exc_o, dslot_hazard_o, hit_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R7 idle valid", valid_o, 0);

    // single zero byte at lane 5: byte format takes, wider formats do not
    begin
      logic [127:0] v = nz_vec();
      v[40 +: 8] = 8'h00;
      for (int df = 0; df < 4; df++) run(mk(2'(df), 5'd7, 16'h0003), v, 32'h1000, 1, 0);
    end
    // zero doubleword in upper lane
    begin
      logic [127:0] v = nz_vec();
      v[127:64] = '0;
      for (int df = 0; df < 4; df++) run(mk(2'(df), 5'd31, 16'h0000), v, 32'h2000, 1, 0);
    end
    run(mk(2'b10, 5'd1, 16'h7fff), nz_vec(), 32'h0000_0100, 1, 0);
    run(mk(2'b10, 5'd1, 16'h8000), '0, 32'h0000_0100, 1, 0);
    run(mk(2'b00, 5'd2, 16'h0010), '0, 32'hffff_fffc, 1, 0);
    run(mk(2'b11, 5'd3, 16'hffff), '0, 32'h0000_0000, 0, 0);
    run({6'b010001, 3'b101, 2'b00, 5'd4, 16'h0001}, '0, 32'h40, 1, 0);
    run({6'b000100, 3'b110, 2'b00, 5'd4, 16'h0001}, '0, 32'h40, 1, 1);
    run(mk(2'b01, 5'd9, 16'h0002), '0, 32'h80, 1, 1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins = $urandom();
      logic [127:0] v = nz_vec();
      if ($urandom_range(0, 9) != 0) ins[31:26] = 6'b010001;
      if ($urandom_range(0, 4) != 0) ins[25:23] = 3'b110;
      if ($urandom_range(0, 1) != 0) begin
        int sz = 8 << $urandom_range(0, 3);
        int k  = $urandom_range(0, 128 / sz - 1);
        for (int b = 0; b < sz; b++) v[k*sz + b] = 1'b0;
      end
      run(ins, v, $urandom(), $urandom_range(0, 5) != 0, $urandom_range(0, 7) == 0);
    end
    @(negedge clk_i);
    chk("R7 idle after burst", {valid_o, taken_o, hit_o}, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule